// File: doc/BRIEF.md
# Configurable Asynchronous Serial Character Receiver

This block takes characters arriving on one serial line and delivers each of them as a parallel byte in a holding register. Line time comes from a one-cycle enable, `tick16`, that pulses sixteen times per bit period. Frame timing is derived only from this enable. The receiver finds the falling edge of a start bit and waits half a bit to confirm it. After that it samples each data, parity and stop bit once, in the middle of the bit.

The frame format is held in a small control register. It is written at run time by holding `cfg_load` high. The format covers the number of data bits (5 to 8), whether a parity bit is present, whether parity is even or odd, and whether one or two stop bits are sent. Each completed character is moved into the holding register, and status is updated at the same time:

- `rx_ready` is raised.
- `err_parity`, `err_frame` and `err_overrun` take new values.

The host reads the byte and drops `dr_clr_n` for a cycle to show that it has been read. The master reset `rst` returns every register to its initial state.

Top module: `serial_char_rx`

## Requirements
- R1: Frame timing advances only on cycles where `tick16` is high. A low line seen on a tick while idle starts a candidate start bit. The line is sampled again 8 ticks later. If it is high at that point, the low is treated as a glitch: no character is produced and the receiver goes back to idle.
- R2: Data bits arrive least significant bit first. Each data, parity and stop bit is sampled once, 16 ticks after the previous sample, which places the sample in the middle of the bit.
- R3: Field `cfg_wlen` selects the number of data bits: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8. A short character is right-justified in `rx_data` with bit 0 as the first received bit, and the unused upper bits are 0.
- R4: When `cfg_par_off` is 1, no parity bit is expected and `err_parity` is 0 after every character. When `cfg_par_off` is 0, one parity bit follows the data bits. With `cfg_par_even` = 1, the data bits and the parity bit together must hold an even number of ones. With `cfg_par_even` = 0, they must hold an odd number. `err_parity` is 1 when this rule is broken.
- R5: The first bit after the parity bit, or after the last data bit when parity is off, is the stop bit. If it is sampled low, `err_frame` is 1.
- R6: With `cfg_two_stop` = 1, only the first stop bit is checked. The receiver stays busy until the middle of the second stop bit before it looks for a new start bit. A frame sent with two stop bits is received without error.
- R7: `err_overrun` is set on a transfer if `rx_ready` was still 1 and no clear was applied in that same cycle. It is 0 after a transfer that finds the previous character read.
- R8: When a character completes, which happens at the stop-bit sample, `rx_data`, `err_parity`, `err_frame` and `err_overrun` are all updated in one clock cycle and `rx_ready` becomes 1. Between transfers these outputs hold their values.
- R9: `dr_clr_n` low clears `rx_ready` on the next clock edge. If a transfer falls in the same cycle, the transfer wins and `rx_ready` stays 1.
- R10: The format fields are captured while `cfg_load` is high and are held while it is low. After reset the format is 8 data bits, parity off, even parity and one stop bit.
- R11: While `rst` is high, `rx_data` is 0 and `rx_ready` and all error flags are 0. A frame that is in progress when reset arrives is dropped. The serial line idles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high, synchronous |
| tick16 | input | 1 | Enable pulsing 16 times per bit period |
| rxd | input | 1 | Serial input; idles high |
| cfg_load | input | 1 | Control register captures the format fields while high |
| cfg_wlen | input | 2 | Data bit count select (0..3 gives 5..8) |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_par_off | input | 1 | 1 removes the parity bit and its check |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| dr_clr_n | input | 1 | Active-low strobe that clears `rx_ready` |
| rx_data | output | 8 | Holding register, right-justified character |
| rx_ready | output | 1 | A character is waiting in the holding register |
| err_parity | output | 1 | Parity mismatch on the last character |
| err_frame | output | 1 | Stop bit sampled low on the last character |
| err_overrun | output | 1 | Last character overwrote an unread one |

## Verification
The host's read-acknowledge strobe and a character transfer can land in the same clock cycle. In that cycle both the ready flag and the overrun decision are affected. The bench counts ticks from the start edge, so it knows exactly which tick samples the stop bit. It drops `dr_clr_n` for that single cycle only, while a previous character is still unread. The outcome is judged correct when `rx_ready` stays high, `err_overrun` is low and the new byte is present. A separate run with no clear at all must raise `err_overrun`.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int unsigned CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_t;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_even;
    logic       par_off;
    logic       two_stop;
  } rx_cfg_t;

  localparam rx_cfg_t CFG_RESET = '{wlen: 2'd3, par_even: 1'b1,
                                    par_off: 1'b1, two_stop: 1'b0};

  // index of the final data bit: 4 + wlen
  function automatic logic [2:0] last_bit_idx(input logic [1:0] wlen);
    return {1'b1, wlen};
  endfunction

  // bits enter at the top of the shifter; move the received ones down
  function automatic logic [CHAR_W-1:0] justify(input logic [CHAR_W-1:0] sh,
                                                input logic [1:0] wlen);
    return sh >> (2'd3 - wlen);
  endfunction

  // high when data plus parity bit break the selected rule
  function automatic logic parity_bad(input logic [CHAR_W-1:0] d,
                                      input logic pbit,
                                      input logic even);
    return (^d) ^ pbit ^ ~even;
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stage <= '1;
        else     stage <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stage <= '1;
        else     stage <= {stage[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/rx_cfg_reg.sv
module rx_cfg_reg
  import serial_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  rx_cfg_t cfg_in,
  output rx_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= CFG_RESET;
    else if (load) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd_s,
  input  rx_cfg_t           cfg,
  output logic              xfer,
  output logic [CHAR_W-1:0] xfer_data,
  output logic              xfer_perr,
  output logic              xfer_ferr,
  output logic              start_ok,
  output logic              glitch
);
  localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OVERSAMPLE - 1);

  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        bit_idx;
  logic [CHAR_W-1:0] shreg;
  logic              pbit;
  logic              bit_end;

  assign bit_end  = tick && (cnt == CNT_FULL);
  assign start_ok = tick && (state == ST_START) && (cnt == CNT_MID) && !rxd_s;
  assign glitch   = tick && (state == ST_START) && (cnt == CNT_MID) &&  rxd_s;
  assign xfer     = bit_end && (state == ST_STOP1);

  assign xfer_data = justify(shreg, cfg.wlen);
  assign xfer_perr = !cfg.par_off && parity_bad(xfer_data, pbit, cfg.par_even);
  assign xfer_ferr = !rxd_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      pbit    <= 1'b0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (!rxd_s) state <= ST_START;
        end
        ST_START: begin
          if (cnt == CNT_MID) begin
            cnt     <= '0;
            bit_idx <= '0;
            state   <= rxd_s ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == CNT_FULL) begin
            cnt   <= '0;
            shreg <= {rxd_s, shreg[CHAR_W-1:1]};
            if (bit_idx == last_bit_idx(cfg.wlen))
              state <= cfg.par_off ? ST_STOP1 : ST_PAR;
            else
              bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt == CNT_FULL) begin
            cnt   <= '0;
            pbit  <= rxd_s;
            state <= ST_STOP1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP1: begin
          if (cnt == CNT_FULL) begin
            cnt   <= '0;
            state <= cfg.two_stop ? ST_STOP2 : ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP2: begin
          if (cnt == CNT_FULL) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/rx_hold_regs.sv
module rx_hold_regs
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer,
  input  logic [CHAR_W-1:0] xfer_data,
  input  logic              xfer_perr,
  input  logic              xfer_ferr,
  input  logic              dr_clr_n,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);
  logic unread_now;
  // a clear in the transfer cycle counts as a completed read
  assign unread_now = rx_ready && dr_clr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else if (xfer) begin
      rx_data     <= xfer_data;
      rx_ready    <= 1'b1;
      err_parity  <= xfer_perr;
      err_frame   <= xfer_ferr;
      err_overrun <= unread_now;
    end else if (!dr_clr_n) begin
      rx_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       cfg_load,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_even,
  input  logic       cfg_par_off,
  input  logic       cfg_two_stop,
  input  logic       dr_clr_n,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun
);
  rx_cfg_t           cfg_in;
  rx_cfg_t           cfg_q;
  logic              rxd_s;
  logic              xfer_evt;
  logic [CHAR_W-1:0] xfer_data;
  logic              xfer_perr;
  logic              xfer_ferr;
  logic              start_evt;
  logic              glitch_evt;

  assign cfg_in = '{wlen: cfg_wlen, par_even: cfg_par_even,
                    par_off: cfg_par_off, two_stop: cfg_two_stop};

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rxd), .q(rxd_s)
  );

  rx_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load), .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  rx_frame_engine #(.OVERSAMPLE(OVERSAMPLE)) u_eng (
    .clk(clk), .rst(rst), .tick(tick16), .rxd_s(rxd_s), .cfg(cfg_q),
    .xfer(xfer_evt), .xfer_data(xfer_data), .xfer_perr(xfer_perr),
    .xfer_ferr(xfer_ferr), .start_ok(start_evt), .glitch(glitch_evt)
  );

  rx_hold_regs u_hold (
    .clk(clk), .rst(rst), .xfer(xfer_evt), .xfer_data(xfer_data),
    .xfer_perr(xfer_perr), .xfer_ferr(xfer_ferr), .dr_clr_n(dr_clr_n),
    .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun)
  );
endmodule

// File: rtl/serial_char_rx_chk.sv
module serial_char_rx_chk
  import serial_rx_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       tick16,
  input logic       dr_clr_n,
  input logic       xfer_evt,
  input logic       start_evt,
  input logic       glitch_evt,
  input rx_cfg_t    cfg_q,
  input logic [7:0] rx_data,
  input logic       rx_ready,
  input logic       err_parity,
  input logic       err_overrun
);
  // R1: confirmation and rejection are exclusive and only happen on a tick
  a_r1_start_on_tick: assert property (@(posedge clk) disable iff (rst)
    (start_evt || glitch_evt) |-> (tick16 && !(start_evt && glitch_evt)));

  // R8: transfers only on a tick, and leave the ready flag set
  a_r8_xfer_on_tick: assert property (@(posedge clk) disable iff (rst)
    xfer_evt |-> tick16);
  a_r8_ready_after_xfer: assert property (@(posedge clk) disable iff (rst)
    xfer_evt |=> rx_ready);
  a_r8_data_holds: assert property (@(posedge clk) disable iff (rst)
    !xfer_evt |=> $stable(rx_data));

  // R9: clear without a transfer drops ready
  a_r9_clear_drops_ready: assert property (@(posedge clk) disable iff (rst)
    (!dr_clr_n && !xfer_evt) |=> !rx_ready);

  // R7: overrun only when the old character was left unread
  a_r7_overrun_needs_unread: assert property (@(posedge clk) disable iff (rst)
    (xfer_evt && !(rx_ready && dr_clr_n)) |=> !err_overrun);

  // R4: parity inhibited keeps the flag low
  a_r4_inhibit_parity: assert property (@(posedge clk) disable iff (rst)
    (xfer_evt && cfg_q.par_off) |=> !err_parity);

  // R3: a 5-bit character leaves the top three bits at zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (xfer_evt && cfg_q.wlen == 2'd0) |=> (rx_data[7:5] == 3'b000));
endmodule

bind serial_char_rx serial_char_rx_chk u_chk (
  .clk(clk), .rst(rst), .tick16(tick16), .dr_clr_n(dr_clr_n),
  .xfer_evt(xfer_evt), .start_evt(start_evt), .glitch_evt(glitch_evt),
  .cfg_q(cfg_q), .rx_data(rx_data), .rx_ready(rx_ready),
  .err_parity(err_parity), .err_overrun(err_overrun)
);

// File: tb/serial_char_rx_test.sv
module serial_char_rx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       cfg_load = 1'b0;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_even = 1'b1;
  logic       cfg_par_off = 1'b1;
  logic       cfg_two_stop = 1'b0;
  logic       dr_clr_n = 1'b1;
  logic [7:0] rx_data;
  logic       rx_ready, err_parity, err_frame, err_overrun;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_char_rx uut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .cfg_load(cfg_load),
    .cfg_wlen(cfg_wlen), .cfg_par_even(cfg_par_even), .cfg_par_off(cfg_par_off),
    .cfg_two_stop(cfg_two_stop), .dr_clr_n(dr_clr_n), .rx_data(rx_data),
    .rx_ready(rx_ready), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun)
  );

  // wlen, even, off, two, corrupt parity, bad stop, data, expected data, pe, fe
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0, 1'b0},
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h1F, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h41, 8'h41, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h41, 8'h41, 1'b1, 1'b0},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h2A, 8'h2A, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h2A, 8'h2A, 1'b1, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 8'h3C, 1'b0, 1'b1},
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 8'h80, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one 16x period: a single-cycle enable, optional single-cycle clear alongside
  task automatic tick(input bit clr = 1'b0);
    tick16 = 1'b1;
    if (clr) dr_clr_n = 1'b0;
    @(negedge clk);
    tick16 = 1'b0;
    dr_clr_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_bit(input logic v);
    rxd = v;
    repeat (16) tick();
  endtask

  task automatic set_cfg(input logic [1:0] w, input logic ev, input logic off, input logic two);
    cfg_wlen = w; cfg_par_even = ev; cfg_par_off = off; cfg_two_stop = two;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] w, input logic ev,
                            input logic off, input logic two, input logic corrupt,
                            input logic badstop, input bit collide);
    int nb;
    logic [7:0] mask;
    logic pb;
    nb = 5 + int'(w);
    mask = 8'((9'd1 << nb) - 9'd1);
    pb = (^(d & mask)) ^ ~ev ^ corrupt;
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) send_bit(d[i]);
    if (!off) send_bit(pb);
    rxd = ~badstop;
    for (int t = 0; t < 16; t++) tick(collide && t == 9);
    if (two) send_bit(1'b1);
    rxd = 1'b1;
    repeat (20) tick();
  endtask

  task automatic clear_ready();
    dr_clr_n = 1'b0;
    @(negedge clk);
    dr_clr_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset data", rx_data, 0);
    chk("R11 reset ready", rx_ready, 0);
    chk("R11 reset flags", {err_parity, err_frame, err_overrun}, 0);
    rst = 1'b0;
    @(negedge clk);

    // table of formats
    for (int v = 0; v < NV; v++) begin
      logic [24:0] e;
      e = VEC[v];
      set_cfg(e[24:23], e[22], e[21], e[20]);
      send_frame(e[17:10], e[24:23], e[22], e[21], e[20], e[19], e[18], 1'b0);
      chk("R8 ready after frame", rx_ready, 1);
      chk("R2 R3 data", rx_data, e[9:2]);
      chk("R4 parity flag", err_parity, e[1]);
      chk("R5 R6 framing flag", err_frame, e[0]);
      chk("R7 no overrun", err_overrun, 0);
      clear_ready();
      chk("R9 clear drops ready", rx_ready, 0);
    end

    // R1: glitch on the line produces nothing
    set_cfg(2'd3, 1'b1, 1'b1, 1'b0);
    rxd = 1'b0;
    repeat (3) tick();
    rxd = 1'b1;
    repeat (30) tick();
    chk("R1 glitch ignored", rx_ready, 0);
    send_frame(8'h5A, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 frame after glitch", rx_data, 8'h5A);
    clear_ready();

    // R10: format inputs change without load; register keeps 8-bit no parity
    cfg_wlen = 2'd0; cfg_par_off = 1'b0; cfg_par_even = 1'b0;
    repeat (2) @(negedge clk);
    send_frame(8'hC3, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 format held", rx_data, 8'hC3);
    chk("R10 no parity check", err_parity, 0);
    clear_ready();

    // R7: overrun when left unread
    send_frame(8'h11, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(8'h22, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 overrun set", err_overrun, 1);
    chk("R7 newest data", rx_data, 8'h22);
    clear_ready();
    send_frame(8'h33, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 overrun cleared", err_overrun, 0);

    // R9 R7: clear lands exactly in the transfer cycle, prior char unread
    send_frame(8'h44, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 transfer wins over clear", rx_ready, 1);
    chk("R7 same-cycle clear is a read", err_overrun, 0);
    chk("R8 collided data", rx_data, 8'h44);

    // R11: reset mid-frame with a non-default format
    set_cfg(2'd0, 1'b0, 1'b0, 1'b1);
    rxd = 1'b0;
    repeat (5) tick();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rxd = 1'b1;
    chk("R11 reset clears data", rx_data, 0);
    chk("R11 reset clears ready", rx_ready, 0);
    rst = 1'b0;
    cfg_wlen = 2'd3; cfg_par_off = 1'b1; cfg_par_even = 1'b1; cfg_two_stop = 1'b0;
    repeat (20) tick();
    chk("R11 no char from dropped frame", rx_ready, 0);
    send_frame(8'h96, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 default format after reset", rx_data, 8'h96);
    chk("R10 default no parity error", err_parity, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule